// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It receives the reference-divider and feedback-divider output clocks as level signals that are already synchronised into a fast sampling clock. It pairs each rising edge of one with the next rising edge of the other and counts the sampling cycles between them. That count is the phase error. Each pair gives one classification: in-window or out-of-window. The result is reported as a single-cycle in-phase or out-of-phase pulse.

A controller counts runs of same-kind results to move a lock flag with hysteresis. The flag sets after a programmable run of in-phase results and clears after a separate, shorter programmable run of out-of-phase results. While the loop is unlocked, the acceptance window is a small programmable count. Once lock is declared, the window is widened by a power-of-two multiplier, so that normal jitter around lock does not chatter the flag. One configuration bit selects an alternate (non-digital) detection mode. In that mode this detector is parked and its status reads as unlocked.

Top module: `pll_lock_detect`

## Requirements
- R1: After synchronous active-high reset `rst`, `lockStatus` is 0, no event pulse is produced, and all run and measurement counters are cleared.
- R2: For each pair of rising edges (one on `refDivClk`, one on `fbDivClk`, in either order), the phase error is the number of sampling cycles from the first edge to its partner. Each pair produces exactly one single-cycle pulse: `inPhasePulse` when the error is at most the active window, otherwise `outPhasePulse`. The two pulses are never high together.
- R3: While unlocked, the active window is the 3-bit value `cfgWord[10:8]`, in sampling cycles.
- R4: While locked, the active window is `cfgWord[10:8]` multiplied by 2^k, where k is the 2-bit field `cfgWord[12:11]` (k = 0..3 gives ×1, ×2, ×4, ×8).
- R5: While unlocked, `lockStatus` rises after a run of consecutive in-phase results equal to the 5-bit field `cfgWord[4:0]`. A value of 0 acts as 1.
- R6: While locked, `lockStatus` falls after a run of consecutive out-of-phase results equal to the 3-bit field `cfgWord[7:5]`. A value of 0 acts as 1.
- R7: A result of the opposite kind clears the consecutive-run count, so a broken run must start again from zero.
- R8: If a first edge gets no partner within 255 sampling cycles, one out-of-phase pulse is produced and measurement restarts from idle.
- R9: While `cfgWord[14]` is 1, the detector is parked: no event pulses, `lockStatus` is 0, and the counters are held cleared. Setting the bit while locked drops `lockStatus`.
- R10: Rising edges on both inputs in the same sampling cycle are an error of 0 and give an in-phase result, even with a window of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| refDivClk | input | 1 | Synchronised reference-divider output |
| fbDivClk | input | 1 | Synchronised feedback-divider output |
| cfgWord | input | 16 | Configuration: [4:0] lock run, [7:5] loss run, [10:8] window, [12:11] multiplier exponent, [14] alternate-mode select |
| lockStatus | output | 1 | Host-readable lock flag |
| inPhasePulse | output | 1 | One-cycle pulse per in-window edge pair |
| outPhasePulse | output | 1 | One-cycle pulse per out-of-window pair or timeout |

## Verification
The bench drives edge pairs at exactly the window value and one cycle beyond it. It does this both unlocked and locked, in both edge orders, and with coincident edges at a zero window. A design that applies the multiplier before lock, uses `<` instead of `<=`, or mishandles the ordering would classify those pairs the wrong way. Runs that are broken one short of their threshold, and thresholds of zero, expose a run counter that is not cleared or that waits for an extra result. Lone edges check the 255-cycle timeout, and toggling the alternate-mode bit while locked checks the forced unlock. Long constrained-random sequences then mix all of these conditions against a bench model.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  localparam int CFG_W        = 16;
  localparam int LOCK_THR_LSB = 0;
  localparam int LOCK_THR_W   = 5;
  localparam int LOSS_THR_LSB = 5;
  localparam int LOSS_THR_W   = 3;
  localparam int WIN_LSB      = 8;
  localparam int WIN_W        = 3;
  localparam int MUL_LSB      = 11;
  localparam int MUL_W        = 2;
  localparam int MODE_BIT     = 14;

  // strobes from control to the datapath
  typedef struct packed {
    logic wideWin;
    logic holdClear;
  } ctrlStrobe_t;

  // result pulses from the datapath to control
  typedef struct packed {
    logic inPhase;
    logic outPhase;
  } phaseEvt_t;

  typedef enum logic [1:0] {
    MEAS_IDLE     = 2'd0,
    MEAS_WAIT_FB  = 2'd1,
    MEAS_WAIT_REF = 2'd2
  } measState_t;

endpackage

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int WIN_W = 3,
  parameter int MUL_W = 2
) (
  input  logic [WIN_W-1:0]                   winVal,
  input  logic [MUL_W-1:0]                   winMul,
  input  logic                               wideWin,
  output logic [WIN_W+(1<<MUL_W)-2:0]        winLimit
);

  localparam int MUL_STEPS = 1 << MUL_W;
  localparam int SCALED_W  = WIN_W + MUL_STEPS - 1;

  logic [SCALED_W-1:0] baseWin;
  logic [SCALED_W-1:0] scaledOpt [MUL_STEPS];

  assign baseWin = SCALED_W'(winVal);

  // one shifted copy of the base window per multiplier setting
  for (genvar k = 0; k < MUL_STEPS; k++) begin : g_scale
    assign scaledOpt[k] = baseWin << k;
  end

  assign winLimit = wideWin ? scaledOpt[winMul] : baseWin;

endmodule

// File: rtl/lockdet_phase_meas.sv
module lockdet_phase_meas
  import lockdet_pkg::*;
#(
  parameter int ERR_W    = 8,
  parameter int MAX_ERR  = 255,
  parameter int LIMIT_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refIn,
  input  logic               fbIn,
  input  logic [LIMIT_W-1:0] winLimit,
  input  ctrlStrobe_t        ctrl,
  output phaseEvt_t          evt
);

  localparam int CMP_W = ((ERR_W > LIMIT_W) ? ERR_W : LIMIT_W) + 1;

  logic             refPrev, fbPrev;
  logic             refRise, fbRise;
  logic             partnerRise;
  measState_t       state;
  logic [ERR_W-1:0] errCnt;
  logic [ERR_W-1:0] errNext;
  logic             inWin;
  logic             timeoutHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
    end
  end

  assign refRise     = refIn & ~refPrev;
  assign fbRise      = fbIn & ~fbPrev;
  assign partnerRise = (state == MEAS_WAIT_FB) ? fbRise : refRise;
  assign errNext     = errCnt + ERR_W'(1);
  assign inWin       = CMP_W'(errNext) <= CMP_W'(winLimit);
  assign timeoutHit  = (errNext == ERR_W'(MAX_ERR));

  always_ff @(posedge clk) begin
    if (rst || ctrl.holdClear) begin
      state  <= MEAS_IDLE;
      errCnt <= '0;
      evt    <= '0;
    end else begin
      evt <= '0;
      case (state)
        MEAS_IDLE: begin
          errCnt <= '0;
          if (refRise && fbRise) begin
            evt.inPhase <= 1'b1;
          end else if (refRise) begin
            state <= MEAS_WAIT_FB;
          end else if (fbRise) begin
            state <= MEAS_WAIT_REF;
          end
        end
        MEAS_WAIT_FB, MEAS_WAIT_REF: begin
          if (partnerRise) begin
            evt.inPhase  <= inWin;
            evt.outPhase <= ~inWin;
            state        <= MEAS_IDLE;
            errCnt       <= '0;
          end else if (timeoutHit) begin
            evt.outPhase <= 1'b1;
            state        <= MEAS_IDLE;
            errCnt       <= '0;
          end else begin
            errCnt <= errNext;
          end
        end
        default: begin
          state  <= MEAS_IDLE;
          errCnt <= '0;
        end
      endcase
    end
  end

  // R2
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(evt.inPhase && evt.outPhase));

  // R8
  err_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state != MEAS_IDLE) |-> (errCnt < ERR_W'(MAX_ERR)));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.holdClear |=> (evt == '0));

  // R10
  coincident_in_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MEAS_IDLE && refRise && fbRise && !ctrl.holdClear) |=> evt.inPhase);

endmodule

// File: rtl/lockdet_ctrl.sv
module lockdet_ctrl
  import lockdet_pkg::*;
#(
  parameter int LOCK_THR_W = 5,
  parameter int LOSS_THR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  phaseEvt_t             evt,
  input  logic [LOCK_THR_W-1:0] lockThr,
  input  logic [LOSS_THR_W-1:0] lossThr,
  input  logic                  modeAlt,
  output ctrlStrobe_t           ctrl,
  output logic                  lockQ
);

  localparam int RUN_W = (LOCK_THR_W > LOSS_THR_W) ? LOCK_THR_W : LOSS_THR_W;

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runNext;
  logic [RUN_W-1:0] lockTarget;
  logic [RUN_W-1:0] lossTarget;

  assign runNext    = runCnt + RUN_W'(1);
  assign lockTarget = (lockThr == '0) ? RUN_W'(1) : RUN_W'(lockThr);
  assign lossTarget = (lossThr == '0) ? RUN_W'(1) : RUN_W'(lossThr);

  assign ctrl.wideWin   = lockQ;
  assign ctrl.holdClear = modeAlt;

  always_ff @(posedge clk) begin
    if (rst || modeAlt) begin
      lockQ  <= 1'b0;
      runCnt <= '0;
    end else if (evt.inPhase) begin
      if (lockQ) begin
        runCnt <= '0;
      end else if (runNext >= lockTarget) begin
        lockQ  <= 1'b1;
        runCnt <= '0;
      end else begin
        runCnt <= runNext;
      end
    end else if (evt.outPhase) begin
      if (!lockQ) begin
        runCnt <= '0;
      end else if (runNext >= lossTarget) begin
        lockQ  <= 1'b0;
        runCnt <= '0;
      end else begin
        runCnt <= runNext;
      end
    end
  end

  // R5
  lock_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lockQ) |-> $past(evt.inPhase));

  // R6
  lock_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lockQ) |-> ($past(evt.outPhase) || $past(modeAlt)));

  // R9
  alt_mode_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    modeAlt |=> (!lockQ && runCnt == '0));

  // R7
  run_break_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.inPhase && lockQ && !modeAlt) |=> (runCnt == '0));

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lockdet_pkg::*;
#(
  parameter int ERR_W   = 8,
  parameter int MAX_ERR = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refDivClk,
  input  logic             fbDivClk,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             lockStatus,
  output logic             inPhasePulse,
  output logic             outPhasePulse
);

  localparam int LIMIT_W = WIN_W + (1 << MUL_W) - 1;

  ctrlStrobe_t          ctrl;
  phaseEvt_t            evt;
  logic [LIMIT_W-1:0]   winLimit;
  logic                 lockQ;
  logic                 unusedCfgBits;

  assign unusedCfgBits = ^{cfgWord[CFG_W-1], cfgWord[MODE_BIT-1]};

  lockdet_window #(
    .WIN_W (WIN_W),
    .MUL_W (MUL_W)
  ) u_window (
    .winVal   (cfgWord[WIN_LSB +: WIN_W]),
    .winMul   (cfgWord[MUL_LSB +: MUL_W]),
    .wideWin  (ctrl.wideWin),
    .winLimit (winLimit)
  );

  lockdet_phase_meas #(
    .ERR_W   (ERR_W),
    .MAX_ERR (MAX_ERR),
    .LIMIT_W (LIMIT_W)
  ) u_meas (
    .clk      (clk),
    .rst      (rst),
    .refIn    (refDivClk),
    .fbIn     (fbDivClk),
    .winLimit (winLimit),
    .ctrl     (ctrl),
    .evt      (evt)
  );

  lockdet_ctrl #(
    .LOCK_THR_W (LOCK_THR_W),
    .LOSS_THR_W (LOSS_THR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .lockThr (cfgWord[LOCK_THR_LSB +: LOCK_THR_W]),
    .lossThr (cfgWord[LOSS_THR_LSB +: LOSS_THR_W]),
    .modeAlt (cfgWord[MODE_BIT]),
    .ctrl    (ctrl),
    .lockQ   (lockQ)
  );

  assign lockStatus    = lockQ;
  assign inPhasePulse  = evt.inPhase;
  assign outPhasePulse = evt.outPhase;

endmodule

// File: tb/pll_lock_detect_bench.sv
`timescale 1ns/1ps
module pll_lock_detect_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refDiv = 1'b0;
  logic        fbDiv = 1'b0;
  logic [15:0] cfg = 16'h0;
  logic        lockStatus, inPhasePulse, outPhasePulse;

  int checks = 0;
  int errors = 0;
  int inSeen = 0;
  int outSeen = 0;
  bit expLock = 1'b0;
  int expRun = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_lock_detect u_pll_lock_detect (
    .clk           (clk),
    .rst           (rst),
    .refDivClk     (refDiv),
    .fbDivClk      (fbDiv),
    .cfgWord       (cfg),
    .lockStatus    (lockStatus),
    .inPhasePulse  (inPhasePulse),
    .outPhasePulse (outPhasePulse)
  );

  always @(negedge clk) begin
    if (inPhasePulse)  inSeen++;
    if (outPhasePulse) outSeen++;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expWindow();
    int w;
    w = int'(cfg[10:8]);
    if (expLock) w = w << cfg[12:11];   // R4 / R3
    return w;
  endfunction

  // consecutive-run model built from R5, R6, R7
  function automatic void modelEvent(bit isIn);
    int tL, tO;
    if (cfg[14]) return;
    tL = (cfg[4:0] == 0) ? 1 : int'(cfg[4:0]);
    tO = (cfg[7:5] == 0) ? 1 : int'(cfg[7:5]);
    if (isIn == !expLock) begin
      expRun++;
      if (expRun >= (expLock ? tO : tL)) begin
        expLock = !expLock;
        expRun = 0;
      end
    end else begin
      expRun = 0;
    end
  endfunction

  task automatic setCfg(int lt, int lo, int w, int m, bit alt);
    @(negedge clk);
    cfg = 16'h0;
    cfg[4:0] = 5'(lt);
    cfg[7:5] = 3'(lo);
    cfg[10:8] = 3'(w);
    cfg[12:11] = 2'(m);
    cfg[14] = alt;
    if (alt) begin
      expLock = 1'b0;
      expRun = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic sendPair(bit refFirst, int gap, string req);
    int in0, out0;
    bit expIn;
    bit quiet;
    quiet = cfg[14];
    expIn = (gap <= expWindow());
    in0 = inSeen;
    out0 = outSeen;
    for (int i = 0; i <= gap; i++) begin
      @(negedge clk);
      refDiv = refFirst ? (i == 0) : (i == gap);
      fbDiv  = refFirst ? (i == gap) : (i == 0);
    end
    @(negedge clk);
    refDiv = 1'b0;
    fbDiv = 1'b0;
    repeat (6) @(negedge clk);
    if (!quiet) modelEvent(expIn);
    check(inSeen - in0 == ((!quiet && expIn) ? 1 : 0), req, "in-phase pulses",
          inSeen - in0, (!quiet && expIn) ? 1 : 0);
    check(outSeen - out0 == ((!quiet && !expIn) ? 1 : 0), req, "out-of-phase pulses",
          outSeen - out0, (!quiet && !expIn) ? 1 : 0);
    check(lockStatus == expLock, req, "lock status", int'(lockStatus), int'(expLock));
  endtask

  task automatic loneEdge(bit useRef);
    int in0, out0;
    in0 = inSeen;
    out0 = outSeen;
    @(negedge clk);
    refDiv = useRef;
    fbDiv = !useRef;
    @(negedge clk);
    refDiv = 1'b0;
    fbDiv = 1'b0;
    repeat (250) @(negedge clk);
    check(outSeen == out0, "R8", "no pulse before timeout", outSeen - out0, 0);
    repeat (20) @(negedge clk);
    modelEvent(1'b0);
    check(outSeen - out0 == 1, "R8", "timeout out-of-phase", outSeen - out0, 1);
    check(inSeen == in0, "R8", "timeout in-phase", inSeen - in0, 0);
    check(lockStatus == expLock, "R8", "lock after timeout", int'(lockStatus), int'(expLock));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(lockStatus == 1'b0, "R1", "lock in reset", int'(lockStatus), 0);
    check(!inPhasePulse && !outPhasePulse, "R1", "pulses in reset",
          int'(inPhasePulse) + int'(outPhasePulse), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(lockStatus == 1'b0 && inSeen == 0 && outSeen == 0, "R1", "idle after reset",
          int'(lockStatus) + inSeen + outSeen, 0);

    // lock run 3, loss run 2, window 4, multiplier x2
    setCfg(3, 2, 4, 1, 1'b0);
    sendPair(1'b1, 4, "R3");          // boundary, in
    sendPair(1'b1, 5, "R3");          // one beyond, out; R7 clears run
    sendPair(1'b0, 1, "R2");
    sendPair(1'b0, 3, "R2");
    sendPair(1'b1, 5, "R7");          // breaks run one short
    sendPair(1'b0, 2, "R5");
    sendPair(1'b1, 0, "R5");
    sendPair(1'b0, 4, "R5");          // third in a row: locks
    sendPair(1'b1, 8, "R4");          // widened boundary, in
    sendPair(1'b0, 9, "R4");          // out, run 1
    sendPair(1'b1, 6, "R7");          // in clears loss run
    sendPair(1'b1, 9, "R6");
    sendPair(1'b0, 20, "R6");         // second out: unlock

    // zero thresholds act as one
    setCfg(0, 0, 2, 3, 1'b0);
    sendPair(1'b1, 2, "R5");
    sendPair(1'b0, 16, "R4");         // 2 x 8 boundary while locked
    sendPair(1'b0, 17, "R6");

    // coincident edges with zero window
    setCfg(5, 1, 0, 0, 1'b0);
    sendPair(1'b1, 0, "R10");
    sendPair(1'b0, 1, "R10");
    sendPair(1'b0, 0, "R10");

    // lone edges time out
    loneEdge(1'b1);
    loneEdge(1'b0);
    sendPair(1'b1, 200, "R2");        // measured, far outside

    // alternate mode parks the detector
    setCfg(1, 3, 3, 2, 1'b0);
    sendPair(1'b1, 1, "R5");
    check(lockStatus == 1'b1, "R9", "locked before mode switch", int'(lockStatus), 1);
    setCfg(1, 3, 3, 2, 1'b1);
    check(lockStatus == 1'b0, "R9", "mode switch drops lock", int'(lockStatus), 0);
    sendPair(1'b1, 1, "R9");
    sendPair(1'b0, 30, "R9");
    setCfg(2, 3, 3, 2, 1'b0);
    sendPair(1'b1, 3, "R9");          // run restarted from zero
    sendPair(1'b0, 3, "R5");

    // constrained random mix
    for (int blk = 0; blk < 15; blk++) begin
      setCfg(int'($urandom_range(0, 6)), int'($urandom_range(0, 4)),
             int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), 1'b0);
      for (int p = 0; p < 20; p++) begin
        int lim;
        lim = 2 * expWindow() + 3;
        if (lim > 200) lim = 200;
        sendPair(1'($urandom_range(0, 1)), int'($urandom_range(0, lim)), "R2");
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule